// File: doc/BRIEF.md
# Scanline Timing Interrupt Generator

This block keeps the raster position of a display: a dot counter paces each scanline, and a line counter steps through the visible lines and then the vertical-blank lines of every frame. From that position it raises three kinds of interrupt request for an interrupt controller. One comes on entry to vertical blank. One comes each time the drawn part of a line ends. One comes at the start of a line whose number equals a programmed compare value.

Software programs one 16-bit control and status word. Three enable bits gate the three requests, and the upper byte holds the compare line number. Reading the word returns the stored settings, and its three lowest bits show live status: in vertical blank, in horizontal blank, and on the compare line. Each request leaves the block as a pulse one clock wide. The current line number is also driven out. The number of dots per line is a parameter and is kept small for simulation.

Top module: `scan_irq_gen`

## Requirements
- R1: While reset is held, the line output is 0, all three request outputs are low, and the status word reads 0x0004. At that point every setting is cleared, and line 0 matches the cleared compare value of 0.
- R2: The line number advances by one every DOTS_PER_LINE clocks. It counts 0 to 227 and then returns to 0.
- R3: With bit 4 of the word set, `irq_hblank` pulses once per line, in the first clock where the dot position equals DRAW_DOTS (the end of the drawn region). This also happens on lines 160 to 227.
- R4: With bit 3 set, `irq_vblank` pulses once per frame, in the first clock of line 160.
- R5: With bit 5 set, `irq_match` pulses in the first clock (dot 0) of the line whose number equals bits 15:8 of the word. This includes line 0, which is reached by wrapping from 227.
- R6: Status bit 0 reads 1 on lines 160 to 227. Bit 1 reads 1 while the dot position is at or past DRAW_DOTS. Bit 2 reads 1 while the line number equals the compare byte.
- R7: A request whose enable bit is clear produces no pulse.
- R8: A write stores bits 3, 4, 5 and 15:8. Written values of bits 0 to 2, 6 and 7 are ignored. Bits 6 and 7 always read 0.
- R9: Every request pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Write data: enables in bits 5:3, compare line in bits 15:8 |
| stat_rdata | output | 16 | Stored settings plus live status in bits 2:0 |
| line_o | output | 8 | Current line number |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_hblank | output | 1 | Horizontal-blank request pulse |
| irq_match | output | 1 | Line-compare request pulse |

## Verification
With the compare byte set to 160, the vertical-blank request and the line-match request are due in the same clock, the first clock of line 160. The bench enables both and programs that compare value. It then checks that both pulses rise together, that each appears exactly once in a full frame, and that line 159 was showing in the sample before. The horizontal-blank request is also checked inside vertical blank, where it must keep firing at the same dot offset.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
    localparam int CMP_W    = 8;
    localparam int STAT_W   = 16;
    localparam int NUM_SRC  = 3;
    // request index: status bit k and enable bit EN_LSB+k belong to source k
    localparam int SRC_VBL   = 0;
    localparam int SRC_HBL   = 1;
    localparam int SRC_MATCH = 2;
    localparam int EN_LSB    = 3;
    localparam int CMP_LSB   = 8;
    localparam logic [STAT_W-1:0] WR_MASK =
        STAT_W'({CMP_W{1'b1}}) << CMP_LSB | STAT_W'({NUM_SRC{1'b1}}) << EN_LSB;

    typedef struct packed {
        logic [CMP_W-1:0]   cmp;
        logic [NUM_SRC-1:0] en;
    } cfg_t;
endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int DOTS   = 8,
    parameter int LINES  = 228,
    parameter int DOT_W  = $clog2(DOTS),
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              eol_o,
    output logic [LINE_W-1:0] next_line_o
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

    typedef struct packed {
        logic [DOT_W-1:0]  dot;
        logic [LINE_W-1:0] line;
    } cnt_t;

    cnt_t              cnt_d, cnt_q;
    logic              eol;
    logic [LINE_W-1:0] nline;

    always_comb begin
        eol   = (cnt_q.dot == DOT_LAST);
        nline = (cnt_q.line == LINE_LAST) ? '0 : cnt_q.line + 1'b1;
        cnt_d = cnt_q;
        if (eol) begin
            cnt_d.dot  = '0;
            cnt_d.line = nline;
        end else begin
            cnt_d.dot  = cnt_q.dot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign dot_o       = cnt_q.dot;
    assign line_o      = cnt_q.line;
    assign eol_o       = eol;
    assign next_line_o = nline;
endmodule

// File: rtl/stat_ctrl_reg.sv
module stat_ctrl_reg
    import scan_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [STAT_W-1:0]    wdata_i,
    input  logic [NUM_SRC-1:0]   live_i,
    output cfg_t                 cfg_o,
    output logic [STAT_W-1:0]    rdata_o
);
    logic [STAT_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we_i) word_d = wdata_i & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign cfg_o.cmp = word_q[CMP_LSB +: CMP_W];
    assign cfg_o.en  = word_q[EN_LSB +: NUM_SRC];
    assign rdata_o   = word_q | STAT_W'(live_i);
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
    import scan_irq_pkg::*;
#(
    parameter int DRAW_DOTS = 5,
    parameter int VIS_LINES = 160,
    parameter int DOT_W     = 3,
    parameter int LINE_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DOT_W-1:0]   dot_i,
    input  logic [LINE_W-1:0]  line_i,
    input  logic               eol_i,
    input  logic [LINE_W-1:0]  next_line_i,
    input  cfg_t               cfg_i,
    output logic [NUM_SRC-1:0] pulse_o
);
    localparam logic [DOT_W-1:0]  HBL_PRE  = DOT_W'(DRAW_DOTS - 1);
    localparam logic [LINE_W-1:0] VIS_LAST = LINE_W'(VIS_LINES - 1);

    typedef struct packed {
        logic [NUM_SRC-1:0] pulse;
    } pls_t;

    pls_t               pls_d, pls_q;
    logic [NUM_SRC-1:0] trig;
    logic [NUM_SRC-1:0] armed;

    // events are detected one clock early so the registered pulse
    // lines up with the first clock of the new position
    always_comb begin
        trig            = '0;
        trig[SRC_VBL]   = eol_i && (line_i == VIS_LAST);
        trig[SRC_HBL]   = (dot_i == HBL_PRE);
        trig[SRC_MATCH] = eol_i && (next_line_i == LINE_W'(cfg_i.cmp));
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_arm
        assign armed[k] = trig[k] & cfg_i.en[k];
    end

    always_comb begin
        pls_d.pulse = armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign pulse_o = pls_q.pulse;
endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
    import scan_irq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 8,
    parameter int DRAW_DOTS     = 5,
    parameter int VIS_LINES     = 160,
    parameter int LINES         = 228
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [STAT_W-1:0] cfg_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [CMP_W-1:0]  line_o,
    output logic              irq_vblank,
    output logic              irq_hblank,
    output logic              irq_match
);
    localparam int DOT_W  = $clog2(DOTS_PER_LINE);
    localparam int LINE_W = CMP_W;

    logic [DOT_W-1:0]   dot;
    logic [LINE_W-1:0]  line;
    logic [LINE_W-1:0]  next_line;
    logic               eol;
    cfg_t               cfg;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] pulse;

    scan_counter #(
        .DOTS   (DOTS_PER_LINE),
        .LINES  (LINES),
        .DOT_W  (DOT_W),
        .LINE_W (LINE_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .dot_o       (dot),
        .line_o      (line),
        .eol_o       (eol),
        .next_line_o (next_line)
    );

    always_comb begin
        live            = '0;
        live[SRC_VBL]   = (line >= LINE_W'(VIS_LINES));
        live[SRC_HBL]   = (dot >= DOT_W'(DRAW_DOTS));
        live[SRC_MATCH] = (line == cfg.cmp);
    end

    stat_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .live_i  (live),
        .cfg_o   (cfg),
        .rdata_o (stat_rdata)
    );

    irq_pulse_gen #(
        .DRAW_DOTS (DRAW_DOTS),
        .VIS_LINES (VIS_LINES),
        .DOT_W     (DOT_W),
        .LINE_W    (LINE_W)
    ) u_pls (
        .clk         (clk),
        .rst_n       (rst_n),
        .dot_i       (dot),
        .line_i      (line),
        .eol_i       (eol),
        .next_line_i (next_line),
        .cfg_i       (cfg),
        .pulse_o     (pulse)
    );

    assign line_o     = line;
    assign irq_vblank = pulse[SRC_VBL];
    assign irq_hblank = pulse[SRC_HBL];
    assign irq_match  = pulse[SRC_MATCH];
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
    parameter int LINES     = 228,
    parameter int VIS_LINES = 160
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] stat_rdata,
    input logic [7:0]  line_o,
    input logic        irq_vblank,
    input logic        irq_hblank,
    input logic        irq_match
);
    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(line_o) < LINES);

    // R3
    hbl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |-> stat_rdata[1] && !$past(stat_rdata[1]));

    // R4
    vbl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |-> int'(line_o) == VIS_LINES && !$past(stat_rdata[0]));

    // R5
    match_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> line_o == $past(stat_rdata[15:8]) && !stat_rdata[1]);

    // R6
    match_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match && !$past(cfg_we) |-> stat_rdata[2]);

    // R7
    vbl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |-> $past(stat_rdata[3]));

    // R7
    hbl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |-> $past(stat_rdata[4]));

    // R7
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> $past(stat_rdata[5]));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[7:6] == 2'b00);

    // R9
    vbl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> !irq_vblank);

    // R9
    hbl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |=> !irq_hblank);

    // R9
    match_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |=> !irq_match);
endmodule

bind scan_irq_gen scan_irq_chk #(
    .LINES     (LINES),
    .VIS_LINES (VIS_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .stat_rdata (stat_rdata),
    .line_o     (line_o),
    .irq_vblank (irq_vblank),
    .irq_hblank (irq_hblank),
    .irq_match  (irq_match)
);

// File: tb/scan_irq_gen_bench.sv
`timescale 1ns/1ps
module scan_irq_gen_bench;
    localparam int DOTS  = 8;
    localparam int DRAW  = 5;
    localparam int VIS   = 160;
    localparam int LINES = 228;
    localparam int FRAME = DOTS * LINES;
    localparam int NVEC  = 9;

    // {control word, expected vblank, hblank, match pulses per frame}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h5038, 8'd1, 8'd228, 8'd1},
        {16'h0010, 8'd0, 8'd228, 8'd0},
        {16'h0000, 8'd0, 8'd0,   8'd0},
        {16'h0020, 8'd0, 8'd0,   8'd1},
        {16'hE320, 8'd0, 8'd0,   8'd1},
        {16'hFA38, 8'd1, 8'd228, 8'd0},
        {16'hA028, 8'd1, 8'd0,   8'd1},
        {16'h0008, 8'd1, 8'd0,   8'd0},
        {16'h9FC7, 8'd0, 8'd0,   8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [15:0] stat_rdata;
    logic [7:0]  line_o;
    logic        irq_vblank, irq_hblank, irq_match;

    always #2.5 clk = ~clk;

    scan_irq_gen #(
        .DOTS_PER_LINE (DOTS),
        .DRAW_DOTS     (DRAW),
        .VIS_LINES     (VIS),
        .LINES         (LINES)
    ) u_scan_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .stat_rdata (stat_rdata),
        .line_o     (line_o),
        .irq_vblank (irq_vblank),
        .irq_hblank (irq_hblank),
        .irq_match  (irq_match)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int dbl    = 0;
    logic pv = 0, ph = 0, pm = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // pulse width monitor (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if ((irq_vblank && pv) || (irq_hblank && ph) || (irq_match && pm)) dbl++;
        end
        pv = irq_vblank;
        ph = irq_hblank;
        pm = irq_match;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nv, nh, nm, n;
        logic [7:0] l0, prev;
        logic [15:0] v;
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check(line_o == 0, "R1", "line", int'(line_o), 0);
        check(stat_rdata == 16'h0004, "R1", "status word", int'(stat_rdata), 4);
        check({irq_vblank, irq_hblank, irq_match} == 3'b000, "R1", "pulses",
              int'({irq_vblank, irq_hblank, irq_match}), 0);
        rst_n = 1'b1;

        // vector table: one frame per control word (R3 R4 R5 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i][39:24];
            cfg_write(16'h0000);
            repeat (2) @(negedge clk);
            cfg_write(v);
            check((stat_rdata & 16'hFFF8) == (v & 16'hFF38), "R8", "readback",
                  int'(stat_rdata & 16'hFFF8), int'(v & 16'hFF38));
            repeat (2) @(negedge clk);
            nv = 0; nh = 0; nm = 0;
            for (int c = 0; c < FRAME; c++) begin
                @(negedge clk);
                nv += int'(irq_vblank);
                nh += int'(irq_hblank);
                nm += int'(irq_match);
            end
            check(nv == int'(VEC[i][23:16]), "R4/R7", "vblank count", nv, int'(VEC[i][23:16]));
            check(nh == int'(VEC[i][15:8]),  "R3/R7", "hblank count", nh, int'(VEC[i][15:8]));
            check(nm == int'(VEC[i][7:0]),   "R5/R7", "match count",  nm, int'(VEC[i][7:0]));
        end

        // R2 line period
        l0 = line_o;
        while (line_o == l0) @(negedge clk);
        l0 = line_o;
        n = 0;
        while (line_o == l0) begin @(negedge clk); n++; end
        check(n == DOTS, "R2", "clocks per line", n, DOTS);

        // R2 wrap after the last line
        while (line_o != 8'd227) @(negedge clk);
        n = 0;
        while (line_o == 8'd227) begin @(negedge clk); n++; end
        check(line_o == 0, "R2", "line after wrap", int'(line_o), 0);
        check(n == DOTS, "R2", "clocks on last line", n, DOTS);

        // R4 and R5 in the same clock: compare line 160
        cfg_write(16'hA028);
        prev = line_o;
        while (!irq_vblank) begin prev = line_o; @(negedge clk); end
        check(irq_match == 1'b1, "R5", "match with vblank", int'(irq_match), 1);
        check(line_o == 8'd160, "R4", "vblank line", int'(line_o), 160);
        check(prev == 8'd159, "R4", "line before vblank", int'(prev), 159);
        check(stat_rdata[2:0] == 3'b101, "R6", "status at 160",
              int'(stat_rdata[2:0]), 5);

        // R5 match at dot 0 of line 100
        cfg_write(16'h6420);
        prev = line_o;
        while (!irq_match) begin prev = line_o; @(negedge clk); end
        check(line_o == 8'd100, "R5", "match line", int'(line_o), 100);
        check(prev == 8'd99, "R5", "line before match", int'(prev), 99);
        check(stat_rdata[2:0] == 3'b100, "R6", "status at match",
              int'(stat_rdata[2:0]), 4);

        // R3 horizontal blank inside vertical blank, at dot DRAW
        cfg_write(16'h0010);
        while (line_o != 8'd200) @(negedge clk);
        n = 0;
        while (!irq_hblank) begin @(negedge clk); n++; end
        check(n == DRAW, "R3", "hblank dot offset", n, DRAW);
        check(line_o == 8'd200, "R3", "hblank line", int'(line_o), 200);
        check(stat_rdata[1:0] == 2'b11, "R6", "status in hblank of vblank line",
              int'(stat_rdata[1:0]), 3);

        // R9 every pulse one clock wide
        check(dbl == 0, "R9", "double-width pulses", dbl, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule